// File: doc/BRIEF.md
# Per-Bit Input Settling Filter

This block conditions a bank of input bits before they are captured as readable input data and before they reach edge and level interrupt detection. Every bit has its own filter enable. With the enable set, the bit's output only moves to a new value once that value has been seen on the raw input at a run of consecutive clock edges. The run length is a parameter and defaults to 16. With the enable clear, the raw bit goes straight to the output through a multiplexer, with no register in the path.

Each bit's filter keeps working while that bit is bypassed, so setting the enable later hands over to a filter state that has already been tracking the input. Because a pin driven as an output loops back through this path, turning the filter on for such a pin delays every output change by the run length before it shows on the input side.

Top module: `pin_settle_filter`

## Requirements
- R1: While reset is asserted, and right after it is released, every enabled bit of `dout_o` reads 0, whatever the raw input is.
- R2: For an enabled bit, a new raw value held across 16 consecutive rising clock edges appears on `dout_o` just after the 16th of those edges, and not before.
- R3: For an enabled bit, a new raw value that lasts for 15 rising edges or fewer and then reverts never appears on `dout_o`.
- R4: For a bypassed bit (enable 0), `dout_o` follows the raw bit combinationally, in the same time step and with no clock edge.
- R5: Bits are independent. A change on one raw bit neither restarts nor speeds up the filter of any other bit.
- R6: The filter of a bit keeps sampling while that bit is bypassed. Setting the enable shows the value that bit's filter has already accepted, at once. This is the raw value if the raw value has been stable for 16 edges, and the previously accepted value otherwise.
- R7: Once a value has been accepted, holding the raw input steady for any number of further edges keeps the output steady. The run count saturates and does not wrap around.
- R8: Any edge that samples a raw value different from the previous sample restarts the run. After a glitch, the output updates exactly 16 edges after the last change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | WIDTH (32) | Unconditioned input bits |
| filt_en_i | input | WIDTH (32) | Per-bit filter enable, 1 = filtered, 0 = bypassed |
| dout_o | output | WIDTH (32) | Conditioned bits |

## Verification
On every cycle, assertions inside each lane check the following. A differing sample clears the run counter. The held value only changes after a run of at least 15 counted repeats, and it takes the raw value sampled at that edge. A saturated, settled lane keeps its count and its value. At the top level, an assertion checks that enabling a settled lane shows the raw value at once. Only the bench scenarios can show the exact edge on which an update lands, the rejection of 15-edge pulses, glitch restarts, independence between bits, and the combinational bypass within a single time step. The bench also runs a behavioural run-length model against the output on every clock, both through directed cases and through a long random stretch with occasional enable changes.

// File: rtl/sf_pkg.sv
package sf_pkg;

  // Next value of a run counter: restart on a differing sample, count up on a
  // repeat, and saturate at the terminal count.
  function automatic int unsigned run_step(int unsigned cnt, bit same, int unsigned term);
    if (!same) return 0;
    if (cnt >= term) return term;
    return cnt + 1;
  endfunction

  // True on the edge where the repeat run reaches the required length.
  function automatic bit run_done(int unsigned cnt, bit same, int unsigned term);
    return same && ((cnt + 1) >= term);
  endfunction

endpackage

// File: rtl/sf_lane.sv
module sf_lane
  import sf_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o,
  output logic settled_o
);

  localparam int unsigned TERM = STABLE_CYCLES - 1;
  localparam int unsigned CW   = (STABLE_CYCLES > 2) ? $clog2(STABLE_CYCLES) : 1;

  logic          samp_q;
  logic          filt_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          same;
  logic          accept;

  assign same   = (raw_i == samp_q);
  assign cnt_d  = CW'(run_step(32'(cnt_q), same, TERM));
  assign accept = run_done(32'(cnt_q), same, TERM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b0;
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      samp_q <= raw_i;
      cnt_q  <= cnt_d;
      if (accept) filt_q <= samp_q;
    end
  end

  assign filt_o    = filt_q;
  assign settled_o = same && (cnt_q == CW'(TERM));

  // R8: a differing sample restarts the run
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i != samp_q) |=> (cnt_q == '0))
    else $error("lane run did not restart");

  // R2: the held value only moves after a full run
  p_change_after_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> ($past(cnt_q) >= CW'(TERM - 1)))
    else $error("lane value changed before full run");

  // R2: an accepted value is the raw value sampled at that edge
  p_takes_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> (filt_q == $past(raw_i)))
    else $error("lane accepted a value not on the input");

  // R7: saturated run holds count and value
  p_saturate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled_o |=> ((cnt_q == CW'(TERM)) && $stable(filt_q)))
    else $error("saturated lane moved");

endmodule

// File: rtl/sf_select.sv
module sf_select #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] raw_i,
  input  logic [WIDTH-1:0] filt_i,
  input  logic [WIDTH-1:0] en_i,
  output logic [WIDTH-1:0] dout_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_mux
    assign dout_o[g] = en_i[g] ? filt_i[g] : raw_i[g];
  end

endmodule

// File: rtl/pin_settle_filter.sv
module pin_settle_filter #(
  parameter int unsigned WIDTH         = 32,
  parameter int unsigned STABLE_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  input  logic [WIDTH-1:0] filt_en_i,
  output logic [WIDTH-1:0] dout_o
);

  logic [WIDTH-1:0] lane_filt;
  logic [WIDTH-1:0] lane_settled;

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    sf_lane #(.STABLE_CYCLES(STABLE_CYCLES)) i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .raw_i    (raw_i[g]),
      .filt_o   (lane_filt[g]),
      .settled_o(lane_settled[g])
    );

    // R6: enabling a settled lane shows the raw value immediately
    p_enable_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(filt_en_i[g]) && lane_settled[g]) |-> (dout_o[g] == raw_i[g]))
      else $error("enable produced a stale value");
  end

  sf_select #(.WIDTH(WIDTH)) i_select (
    .raw_i (raw_i),
    .filt_i(lane_filt),
    .en_i  (filt_en_i),
    .dout_o(dout_o)
  );

endmodule

// File: tb/test_pin_settle_filter.sv
module test_pin_settle_filter;

  localparam int W          = 32;
  localparam int RUN        = 16;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] raw = '1;
  logic [W-1:0] en  = '1;
  logic [W-1:0] dout;

  int checks = 0;
  int errors = 0;

  bit last_s [W];
  bit acc_v  [W];
  int runlen [W];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_settle_filter #(.WIDTH(W), .STABLE_CYCLES(RUN)) i_pin_settle_filter (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .filt_en_i(en), .dout_o(dout)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural run-length model, compared shortly after every rising edge
  always @(posedge clk) begin
    for (int b = 0; b < W; b++) begin
      if (!rst_n) begin
        last_s[b] = 1'b0; runlen[b] = 1; acc_v[b] = 1'b0;
      end else begin
        if (raw[b] == last_s[b]) begin
          if (runlen[b] < RUN) runlen[b] = runlen[b] + 1;
        end else begin
          last_s[b] = raw[b]; runlen[b] = 1;
        end
        if (runlen[b] >= RUN) acc_v[b] = last_s[b];
      end
    end
    #2;
    for (int b = 0; b < W; b++) begin
      if (en[b]) chk("R2 model", dout[b], acc_v[b]);
      else       chk("R4 model", dout[b], raw[b]);
    end
  end

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_neg(3);
    chk("R1 in reset", dout[0], 1'b0);
    chk("R1 in reset", dout[31], 1'b0);
    rst_n = 1'b1;
    wait_neg(1);
    chk("R1 after release", dout[7], 1'b0);
    wait_neg(20);
    chk("R2 initial settle", dout[9], 1'b1);

    // R2: exact update edge
    raw[0] = 1'b0;
    wait_neg(15); chk("R2 before 16th edge", dout[0], 1'b1);
    wait_neg(1);  chk("R2 at 16th edge", dout[0], 1'b0);

    // R3: 15-edge pulse rejected
    raw[3] = 1'b0;
    wait_neg(15); raw[3] = 1'b1;
    wait_neg(30); chk("R3 short pulse", dout[3], 1'b1);

    // R8: glitch restarts the run
    raw[4] = 1'b0;
    wait_neg(10); raw[4] = 1'b1;
    wait_neg(1);  raw[4] = 1'b0;
    wait_neg(15); chk("R8 before restart run", dout[4], 1'b1);
    wait_neg(1);  chk("R8 after restart run", dout[4], 1'b0);

    // R5: independent bits
    raw[1] = 1'b0;
    wait_neg(5);  raw[2] = 1'b0;
    wait_neg(11);
    chk("R5 bit1 done", dout[1], 1'b0);
    chk("R5 bit2 pending", dout[2], 1'b1);
    wait_neg(5);  chk("R5 bit2 done", dout[2], 1'b0);

    // R7: long hold stays put
    wait_neg(40);
    chk("R7 hold bit0", dout[0], 1'b0);
    chk("R7 hold bit2", dout[2], 1'b0);

    // R4: bypass is combinational
    en[5] = 1'b0;
    raw[5] = 1'b0; #1 chk("R4 bypass low", dout[5], 1'b0);
    raw[5] = 1'b1; #1 chk("R4 bypass high", dout[5], 1'b1);
    raw[5] = 1'b0; #1 chk("R4 bypass low again", dout[5], 1'b0);

    // R6: state runs while bypassed
    wait_neg(20);
    en[5] = 1'b1; #1 chk("R6 settled handover", dout[5], 1'b0);
    wait_neg(1);
    en[5] = 1'b0; raw[5] = 1'b1;
    wait_neg(5);
    en[5] = 1'b1; #1 chk("R6 unsettled shows old", dout[5], 1'b0);
    wait_neg(11); chk("R6 completes run", dout[5], 1'b1);

    // Random stretch against the model
    for (int c = 0; c < 3000; c++) begin
      wait_neg(1);
      for (int b = 0; b < W; b++) begin
        if ($urandom_range(0, 39) == 0) raw[b] = ~raw[b];
        if ($urandom_range(0, 199) == 0) en[b] = ~en[b];
      end
    end

    wait_neg(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule